// File: doc/BRIEF.md
# Single to half precision float narrower

The block takes a 32-bit binary32 operand and produces the 16-bit binary16 value under one of five rounding behaviours. The rounding increment is decided on the binary32 fraction: the kept bit is fraction bit 13, the guard bit is bit 12, the round bit is bit 11 and the sticky bit is the OR of bits 10 to 0. The increment is added at bit 13 of the operand, so a carry that leaves the fraction raises the exponent. The rounded exponent then decides the result class. It can be a signed zero, a half subnormal taken by shifting the 11-bit significand right, a half normal, or a signed infinity on overflow. Binary32 zeros, binary32 subnormals, infinities and NaNs skip the increment.

The operand and rounding code are captured with a valid strobe. The result and three flags (overflow, underflow, inexact) appear one clock later with their own valid strobe. They hold their value until the next strobe.

Top module: `nrw_top`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. The result and flags in that cycle belong to the operand presented with the strobe, so latency is one clock.
- R2: While `in_valid` is low, `out_res` and the three flags keep their previous values, whatever `in_op` and `in_rm` carry.
- R3: Rounding code 0 is nearest-even, 1 is toward zero, 2 is toward minus infinity, 3 is toward plus infinity and 4 is nearest with ties away from zero. Codes 5, 6 and 7 truncate, like code 1.
- R4: Nearest-even adds one at operand bit 13 when bit 12 is set and any of bit 13, bit 11 or bits 10..0 is set; otherwise it truncates. Ties-away adds one whenever bit 12 is set.
- R5: Toward plus infinity adds one when bits 12..0 are nonzero and the sign is 0. Toward minus infinity adds one when bits 12..0 are nonzero and the sign is 1. Toward zero never adds.
- R6: A carry out of the fraction raises the exponent. For example, 0x3FFFF000 under nearest-even gives 0x4000.
- R7: Let the rounded exponent field be E and let e = E - 127. If e < -24 the result is a zero of the input sign. If -24 <= e < -14 the result is {1, kept 10 fraction bits} shifted right by (-e - 14). If e < 16 the result has exponent field e + 15 and the kept 10 fraction bits. Otherwise it is infinity (0x7C00 with the input sign) in every rounding mode.
- R8: An input with exponent field 0 gives a zero of its sign. An infinity keeps its sign. Every NaN gives 0x7E00.
- R9: Inexact (`out_inx`) is set for a finite input when a discarded bit was nonzero. This covers bits 12..0, bits shifted out on the subnormal path, any nonzero input flushed to zero, and every overflow. Underflow (`out_unf`) is inexact with a zero or subnormal result. Overflow (`out_ovf`) marks the infinity case of R7. NaN, infinity and zero inputs raise no flag.
- R10: During reset `out_valid`, `out_res` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operand strobe |
| in_op | input | 32 | binary32 operand |
| in_rm | input | 3 | Rounding code |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_res | output | 16 | binary16 result |
| out_ovf | output | 1 | Overflow flag |
| out_unf | output | 1 | Underflow flag |
| out_inx | output | 1 | Inexact flag |

## Verification
Some properties are checked on every cycle:
- the one-cycle valid relation;
- hold of the result and flags while no strobe arrives;
- sign preservation for non-NaN operands;
- the canonical NaN output;
- overflow always paired with an infinite magnitude;
- underflow always paired with inexact, and never together with overflow.

The bench alone shows the exact rounding decisions in each mode, including tie handling and codes 5 to 7. It also shows the carry into the exponent and the threshold placement at each rounded exponent from 100 to 146. These come from directed boundary operands and seeded random operands, checked against a bench-side reference.

// File: rtl/nrw_pkg.sv
package nrw_pkg;
  localparam int S_EXP_W  = 8;
  localparam int S_FRAC_W = 23;
  localparam int H_EXP_W  = 5;
  localparam int H_FRAC_W = 10;
  localparam int S_W      = 1 + S_EXP_W + S_FRAC_W;
  localparam int H_W      = 1 + H_EXP_W + H_FRAC_W;
  localparam int PAD      = S_FRAC_W - H_FRAC_W;
  localparam int KEEP_W   = S_EXP_W + H_FRAC_W;
  localparam int S_BIAS   = (1 << (S_EXP_W - 1)) - 1;
  localparam int H_BIAS   = (1 << (H_EXP_W - 1)) - 1;
  localparam int H_EMIN   = 1 - H_BIAS;
  localparam int ZERO_LIM = S_BIAS + H_EMIN - H_FRAC_W;
  localparam int SUB_LIM  = S_BIAS + H_EMIN;
  localparam int OVF_LIM  = S_BIAS + H_BIAS + 1;
  localparam int REBIAS   = S_BIAS - H_BIAS;
  localparam int SH_W     = $clog2(H_FRAC_W + 1);
  localparam int RM_W     = 3;

  typedef enum logic [RM_W-1:0] {
    RM_NEAR_EVEN = 3'd0,
    RM_TO_ZERO   = 3'd1,
    RM_TO_NEG    = 3'd2,
    RM_TO_POS    = 3'd3,
    RM_NEAR_AWAY = 3'd4
  } rm_e;

  typedef enum logic [2:0] {
    CL_ZIN,
    CL_UNDER,
    CL_SUB,
    CL_NORM,
    CL_OVF,
    CL_INF,
    CL_NAN
  } cls_e;

  typedef struct packed {
    logic           ovf;
    logic           unf;
    logic           inx;
    logic [H_W-1:0] res;
  } nrw_out_t;
endpackage

// File: rtl/nrw_rst_sync.sv
module nrw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/nrw_round.sv
module nrw_round
  import nrw_pkg::*;
(
  input  logic [S_W-1:0]    op,
  input  logic [RM_W-1:0]   rm,
  output logic [KEEP_W-1:0] kept,
  output logic              lost,
  output logic              exp_zero,
  output logic              exp_ones,
  output logic              frac_nz
);
  logic [S_EXP_W-1:0] exp_f;
  logic               sgn;
  logic               lsb_b, grd_b, rnd_b, stk_b;
  logic               bump;
  logic               bypass;

  always_comb begin
    sgn      = op[S_W-1];
    exp_f    = op[S_W-2 -: S_EXP_W];
    exp_zero = (exp_f == '0);
    exp_ones = (exp_f == '1);
    frac_nz  = |op[S_FRAC_W-1:0];
    bypass   = exp_zero | exp_ones;
    lsb_b    = op[PAD];
    grd_b    = op[PAD-1];
    rnd_b    = op[PAD-2];
    stk_b    = |op[PAD-3:0];
    lost     = |op[PAD-1:0];
    unique case (rm)
      RM_NEAR_EVEN: bump = grd_b & (rnd_b | stk_b | lsb_b);
      RM_NEAR_AWAY: bump = grd_b;
      RM_TO_POS:    bump = lost & ~sgn;
      RM_TO_NEG:    bump = lost & sgn;
      default:      bump = 1'b0;
    endcase
    if (bypass) bump = 1'b0;
    kept = op[S_W-2:PAD] + {{(KEEP_W-1){1'b0}}, bump};
  end
endmodule

// File: rtl/nrw_pack.sv
module nrw_pack
  import nrw_pkg::*;
(
  input  logic              sgn,
  input  logic [KEEP_W-1:0] kept,
  input  logic              lost,
  input  logic              exp_zero,
  input  logic              exp_ones,
  input  logic              frac_nz,
  output nrw_out_t          pk
);
  logic [S_EXP_W-1:0]  rexp;
  logic [H_FRAC_W-1:0] rfrac;
  logic [H_FRAC_W:0]   sig;
  logic [H_FRAC_W:0]   sub_mask;
  logic [H_FRAC_W:0]   sub_val;
  logic [SH_W-1:0]     sh;
  logic                sub_lost;
  logic [H_EXP_W-1:0]  hexp;
  cls_e                cls;

  always_comb begin
    rexp     = kept[KEEP_W-1 -: S_EXP_W];
    rfrac    = kept[H_FRAC_W-1:0];
    sig      = {1'b1, rfrac};
    sh       = SH_W'(S_EXP_W'(SUB_LIM) - rexp);
    sub_mask = ({{H_FRAC_W{1'b0}}, 1'b1} << sh) - 1'b1;
    sub_val  = sig >> sh;
    sub_lost = |(sig & sub_mask);
    hexp     = H_EXP_W'(rexp - S_EXP_W'(REBIAS));

    if (exp_ones)                          cls = frac_nz ? CL_NAN : CL_INF;
    else if (exp_zero)                     cls = CL_ZIN;
    else if (rexp < S_EXP_W'(ZERO_LIM))    cls = CL_UNDER;
    else if (rexp < S_EXP_W'(SUB_LIM))     cls = CL_SUB;
    else if (rexp < S_EXP_W'(OVF_LIM))     cls = CL_NORM;
    else                                   cls = CL_OVF;

    pk = '0;
    unique case (cls)
      CL_NAN: pk.res = {1'b0, {H_EXP_W{1'b1}}, 1'b1, {(H_FRAC_W-1){1'b0}}};
      CL_INF: pk.res = {sgn, {H_EXP_W{1'b1}}, {H_FRAC_W{1'b0}}};
      CL_ZIN: begin
        pk.res = {sgn, {(H_W-1){1'b0}}};
        pk.inx = frac_nz;
        pk.unf = frac_nz;
      end
      CL_UNDER: begin
        pk.res = {sgn, {(H_W-1){1'b0}}};
        pk.inx = 1'b1;
        pk.unf = 1'b1;
      end
      CL_SUB: begin
        pk.res = {sgn, {H_EXP_W{1'b0}}, sub_val[H_FRAC_W-1:0]};
        pk.inx = lost | sub_lost;
        pk.unf = lost | sub_lost;
      end
      CL_NORM: begin
        pk.res = {sgn, hexp, rfrac};
        pk.inx = lost;
      end
      default: begin
        pk.res = {sgn, {H_EXP_W{1'b1}}, {H_FRAC_W{1'b0}}};
        pk.ovf = 1'b1;
        pk.inx = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/nrw_top.sv
module nrw_top
  import nrw_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [S_W-1:0]  in_op,
  input  logic [RM_W-1:0] in_rm,
  output logic            out_valid,
  output logic [H_W-1:0]  out_res,
  output logic            out_ovf,
  output logic            out_unf,
  output logic            out_inx
);
  logic              rst_sync_n;
  logic [KEEP_W-1:0] kept;
  logic              lost, exp_zero, exp_ones, frac_nz;
  nrw_out_t          pk;
  nrw_out_t          out_q, out_d;
  logic              vld_q, vld_d;

  nrw_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  nrw_round u_round (
    .op       (in_op),
    .rm       (in_rm),
    .kept     (kept),
    .lost     (lost),
    .exp_zero (exp_zero),
    .exp_ones (exp_ones),
    .frac_nz  (frac_nz)
  );

  nrw_pack u_pack (
    .sgn      (in_op[S_W-1]),
    .kept     (kept),
    .lost     (lost),
    .exp_zero (exp_zero),
    .exp_ones (exp_ones),
    .frac_nz  (frac_nz),
    .pk       (pk)
  );

  always_comb begin
    vld_d = in_valid;
    out_d = in_valid ? pk : out_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= 1'b0;
      out_q <= '0;
    end else begin
      vld_q <= vld_d;
      out_q <= out_d;
    end
  end

  assign out_valid = vld_q;
  assign out_res   = out_q.res;
  assign out_ovf   = out_q.ovf;
  assign out_unf   = out_q.unf;
  assign out_inx   = out_q.inx;
endmodule

// File: rtl/nrw_checker.sv
module nrw_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] in_op,
  input logic        out_valid,
  input logic [15:0] out_res,
  input logic        out_ovf,
  input logic        out_unf,
  input logic        out_inx
);
  logic in_nan;
  assign in_nan = (in_op[30:23] == 8'hFF) && (in_op[22:0] != 23'd0);

  // R1: the strobe follows the input strobe by exactly one clock
  a_r1_valid_on: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_valid_off: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R2: result and flags hold without a strobe
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_res) && $stable(out_ovf) && $stable(out_unf) && $stable(out_inx)));
  // R7: sign carried for every non-NaN operand
  a_r7_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_nan) |=> (out_res[15] == $past(in_op[31])));
  // R8: any NaN yields the canonical quiet NaN
  a_r8_nan: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_nan) |=> (out_res == 16'h7E00));
  // R9: overflow comes with an infinite magnitude and inexact
  a_r9_ovf_inf: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ovf) |-> (out_res[14:0] == 15'h7C00 && out_inx));
  // R9: underflow implies inexact and excludes overflow
  a_r9_unf_inx: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_unf) |-> out_inx);
  a_r9_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_ovf, out_unf}));
endmodule

bind nrw_top nrw_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .in_op     (in_op),
  .out_valid (out_valid),
  .out_res   (out_res),
  .out_ovf   (out_ovf),
  .out_unf   (out_unf),
  .out_inx   (out_inx)
);

// File: tb/tb_nrw_top.sv
`timescale 1ns/1ps
module tb_nrw_top;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_op;
  logic [2:0]  in_rm;
  logic        out_valid;
  logic [15:0] out_res;
  logic        out_ovf, out_unf, out_inx;
  int          n_checks;
  int          n_errors;
  bit          done;

  nrw_top dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_rm(in_rm),
    .out_valid(out_valid), .out_res(out_res), .out_ovf(out_ovf),
    .out_unf(out_unf), .out_inx(out_inx)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // returns {ovf, unf, inx, result}
  function automatic logic [18:0] ref_cvt(input logic [31:0] x, input logic [2:0] m);
    logic s, g, r, st, l, any, up, sl, inx;
    int unsigned mag, ee, fr, m11, q;
    int e, sh;
    s = x[31];
    if (x[30:23] == 8'hFF) return (x[22:0] != 0) ? {3'b000, 16'h7E00} : {3'b000, s, 15'h7C00};
    if (x[30:23] == 8'h00) return {1'b0, x[22:0] != 0, x[22:0] != 0, s, 15'h0000};
    g = x[12]; r = x[11]; st = |x[10:0]; l = x[13]; any = |x[12:0];
    case (m)
      3'd0: up = g && (r || st || l);
      3'd2: up = any && s;
      3'd3: up = any && !s;
      3'd4: up = g;
      default: up = 1'b0;
    endcase
    mag = int'(x[30:13]) + (up ? 1 : 0);
    ee = mag >> 10;
    fr = mag & 1023;
    e  = int'(ee) - 127;
    if (e < -24) return {3'b011, s, 15'h0000};
    if (e < -14) begin
      sh  = -e - 14;
      m11 = fr | 1024;
      q   = m11 >> sh;
      sl  = (m11 & ((1 << sh) - 1)) != 0;
      inx = any || sl;
      return {1'b0, inx, inx, s, 5'd0, q[9:0]};
    end
    if (e < 16) begin
      ee = e + 15;
      return {2'b00, any, s, ee[4:0], fr[9:0]};
    end
    return {3'b101, s, 15'h7C00};
  endfunction

  task automatic compare(input string tag, input logic [18:0] exp_v);
    logic [18:0] act;
    act = {out_ovf, out_unf, out_inx, out_res};
    n_checks++;
    if (act !== exp_v || out_valid !== 1'b1) begin
      n_errors++;
      $display("FAIL %s: op=%h rm=%0d actual={ovf,unf,inx,res}=%h valid=%b expected=%h valid=1",
               tag, in_op, in_rm, act, out_valid, exp_v);
    end
  endtask

  task automatic run(input logic [31:0] op, input logic [2:0] m, input string tag);
    in_valid = 1'b1; in_op = op; in_rm = m;
    @(negedge clk);
    compare(tag, ref_cvt(op, m));
  endtask

  task automatic run_hand(input logic [31:0] op, input logic [2:0] m,
                          input logic [15:0] res, input string tag);
    logic [18:0] e;
    e = ref_cvt(op, m);
    in_valid = 1'b1; in_op = op; in_rm = m;
    @(negedge clk);
    compare(tag, {e[18:16], res});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [18:0] held;
    logic [31:0] op;
    int unsigned seed_dummy;
    n_checks = 0; n_errors = 0; done = 1'b0;
    rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_rm = '0;
    seed_dummy = $urandom(32'h5EED_1234);
    repeat (3) @(negedge clk);
    // R10: reset state
    n_checks++;
    if ({out_valid, out_ovf, out_unf, out_inx, out_res} !== 20'd0) begin
      n_errors++;
      $display("FAIL R10: actual=%h expected=0", {out_valid, out_ovf, out_unf, out_inx, out_res});
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // directed corners
    run_hand(32'h3F800000, 3'd0, 16'h3C00, "R7 one");
    run_hand(32'h3F801000, 3'd0, 16'h3C00, "R4 tie even down");
    run_hand(32'h3F801000, 3'd4, 16'h3C01, "R4 tie away");
    run_hand(32'h3F803000, 3'd0, 16'h3C02, "R4 tie even up");
    run_hand(32'h3F801FFF, 3'd3, 16'h3C01, "R5 toward plus");
    run_hand(32'hBF801FFF, 3'd3, 16'hBC00, "R5 plus on negative");
    run_hand(32'hBF800001, 3'd2, 16'hBC01, "R5 toward minus");
    run_hand(32'h3F801FFF, 3'd1, 16'h3C00, "R5 toward zero");
    run_hand(32'h3F801FFF, 3'd5, 16'h3C00, "R3 code 5");
    run_hand(32'h3F801FFF, 3'd7, 16'h3C00, "R3 code 7");
    run_hand(32'h3FFFF000, 3'd0, 16'h4000, "R6 carry");
    run_hand(32'h477FE000, 3'd0, 16'h7BFF, "R7 max normal");
    run_hand(32'h477FF000, 3'd0, 16'h7C00, "R7 R9 overflow");
    run_hand(32'h477FF000, 3'd1, 16'h7BFF, "R5 truncate below max");
    run_hand(32'h33800000, 3'd0, 16'h0001, "R7 min subnormal");
    run_hand(32'h33000000, 3'd3, 16'h0000, "R7 R9 flush to zero");
    run_hand(32'hFFC00001, 3'd0, 16'h7E00, "R8 NaN");
    run_hand(32'hFF800000, 3'd0, 16'hFC00, "R8 infinity");
    run_hand(32'h80000000, 3'd0, 16'h8000, "R8 negative zero");
    run_hand(32'h00000001, 3'd3, 16'h0000, "R8 R9 input subnormal");
    run_hand(32'h38800000, 3'd0, 16'h0400, "R7 min normal");

    // R2: hold while no strobe
    held = {out_ovf, out_unf, out_inx, out_res};
    in_valid = 1'b0; in_op = 32'h3F800000; in_rm = 3'd0;
    repeat (2) begin
      @(negedge clk);
      n_checks++;
      if ({out_ovf, out_unf, out_inx, out_res} !== held || out_valid !== 1'b0) begin
        n_errors++;
        $display("FAIL R2: actual=%h valid=%b expected=%h valid=0",
                 {out_ovf, out_unf, out_inx, out_res}, out_valid, held);
      end
    end

    // R7 R9 every rounded exponent boundary, every code
    for (int ex = 100; ex <= 146; ex++) begin
      for (int m = 0; m < 8; m++) begin
        op = {1'($urandom_range(0, 1)), 8'(ex), 23'($urandom)};
        run(op, 3'(m), "R7 boundary");
        op = {1'($urandom_range(0, 1)), 8'(ex), 23'h7FF000 | 23'($urandom_range(0, 4095))};
        run(op, 3'(m), "R6 boundary carry");
      end
    end

    // R1 R3 R4 R5 random back-to-back stream
    for (int i = 0; i < 3000; i++) begin
      if (i % 2 == 0) op = {1'($urandom_range(0, 1)), 8'($urandom_range(95, 150)), 23'($urandom)};
      else            op = $urandom;
      run(op, 3'($urandom_range(0, 7)), "R1 R3 R4 R5 random");
    end

    in_valid = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule